// File: doc/BRIEF.md
# GPIO Port Data Register File

This block is a word-addressed register file for one general-purpose I/O port of up to 32 pins. Software sees a data latch that drives the pads, a direction register that enables the pad drivers, and a read-only view of the pad levels. The pad levels pass through a two-flop synchronizer before software can read them. Three further write-only addresses change chosen bits of the data latch in a single bus write: one forces bits high, one forces them low and one inverts them. Because these addresses act only on the bits that are 1 in the write data, software needs no read-modify-write to update a subset of pins.

The data latch can be written while a pin is still an input. A pin's level can therefore be preset, and the pin then starts driving that level on the same edge that its direction bit goes to 1, with no glitch. Reads are combinational from the current register state. Writes take effect at the next rising clock edge.

Word offsets are: 0 data latch (read/write), 1 direction (read/write), 2 pad input view (read-only), 3 force-high alias, 4 force-low alias, 5 invert alias. Offsets 6 and above are unused.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is high, and on the first cycle after it, the data latch and the direction register read as zero, and pad_oe and pad_out are all zero, so that every pin starts as an input.
- R2: pad_oe equals the direction register bit for bit, where 1 means output and 0 means input, and pad_out equals the data latch bit for bit.
- R3: A write to offset 0 replaces every bit of the data latch with bus_wdata.
- R4: A write to offset 1 replaces every bit of the direction register with bus_wdata.
- R5: A write to offset 3 sets to 1 each data latch bit whose bus_wdata bit is 1 and leaves every other bit unchanged.
- R6: A write to offset 4 clears to 0 each data latch bit whose bus_wdata bit is 1 and leaves every other bit unchanged.
- R7: A write to offset 5 inverts each data latch bit whose bus_wdata bit is 1 and leaves every other bit unchanged.
- R8: Writes to offsets 0, 3, 4 and 5 leave the direction register unchanged, and a write to offset 1 leaves the data latch unchanged.
- R9: A read of offset 2 returns the value pad_in held two rising edges earlier. The synchronizer flops reset to zero.
- R10: Reads of offsets 3, 4, 5 and of any unused offset return zero.
- R11: Writes to offset 2 and to unused offsets change neither the data latch nor the direction register.
- R12: A level preset through offset 3 or 4 while a pin is an input appears on pad_out on the same edge that the pin's direction bit is set, with no intermediate value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | NUM_PINS | Write data, or the bit mask for the alias offsets |
| bus_rdata | output | NUM_PINS | Combinational read data for bus_addr |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Level driven to each pad |
| pad_oe | output | NUM_PINS | Pad driver enable, 1 = output |

## Verification
The bench targets alias writes that have zero bits in the mask. A design that let the force-high, force-low or invert path touch unselected bits would corrupt neighbouring pins, and a comparison of the whole latch on every cycle exposes this. It also writes to the read-only input offset and to unused offsets, which a loose decoder would let land on the data latch or the direction register. Other targets are the exact two-edge latency of the input path, which an extra or missing flop would shift by a cycle, and a preset followed by a direction change, where a design that reset the latch on a direction write would drop the preset level.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Word offsets; software and the bench depend on these values.
    localparam int unsigned OFS_DOUT = 0;
    localparam int unsigned OFS_DIR  = 1;
    localparam int unsigned OFS_DIN  = 2;
    localparam int unsigned OFS_SET  = 3;
    localparam int unsigned OFS_CLR  = 4;
    localparam int unsigned OFS_TGL  = 5;

    typedef enum logic [2:0] {
        DOP_HOLD = 3'd0,
        DOP_LOAD = 3'd1,
        DOP_SET  = 3'd2,
        DOP_CLR  = 3'd3,
        DOP_TGL  = 3'd4
    } data_op_e;

    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_DOUT = 2'd1,
        RSEL_DIR  = 2'd2,
        RSEL_DIN  = 2'd3
    } rd_sel_e;

    typedef struct packed {
        data_op_e data_op;
        logic     dir_load;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input int unsigned ofs, input logic we);
        wr_cmd_t c;
        c.data_op  = DOP_HOLD;
        c.dir_load = 1'b0;
        if (we) begin
            case (ofs)
                OFS_DOUT: c.data_op  = DOP_LOAD;
                OFS_DIR:  c.dir_load = 1'b1;
                OFS_SET:  c.data_op  = DOP_SET;
                OFS_CLR:  c.data_op  = DOP_CLR;
                OFS_TGL:  c.data_op  = DOP_TGL;
                default:  ;
            endcase
        end
        return c;
    endfunction

    function automatic rd_sel_e decode_read(input int unsigned ofs);
        case (ofs)
            OFS_DOUT: return RSEL_DOUT;
            OFS_DIR:  return RSEL_DIR;
            OFS_DIN:  return RSEL_DIN;
            default:  return RSEL_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // Cycles since reset, saturating, so the latency check never looks before reset.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        p_latency_r9: assert property (@(posedge clk) disable iff (rst)
            (warm_cnt == 2'd2) |-> (sync_out == $past(async_in, 2)));
    end

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int WIDTH  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  dout_q,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  din_sync,
    output wr_cmd_t           cmd,
    output logic [WIDTH-1:0]  rdata
);
    int unsigned ofs;
    rd_sel_e     rsel;

    always_comb begin
        ofs  = int'(addr);
        cmd  = decode_write(ofs, we);
        rsel = decode_read(ofs);
        case (rsel)
            RSEL_DOUT: rdata = dout_q;
            RSEL_DIR:  rdata = dir_q;
            RSEL_DIN:  rdata = din_sync;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dout_q,
    output logic [WIDTH-1:0] dir_q
);
    logic [WIDTH-1:0] dout_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic nxt;
        always_comb begin
            case (cmd.data_op)
                DOP_LOAD: nxt = wdata[i];
                DOP_SET:  nxt = dout_q[i] | wdata[i];
                DOP_CLR:  nxt = dout_q[i] & ~wdata[i];
                DOP_TGL:  nxt = dout_q[i] ^ wdata[i];
                default:  nxt = dout_q[i];
            endcase
        end
        assign dout_d[i] = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else begin
            dout_q <= dout_d;
            if (cmd.dir_load) dir_q <= wdata;
        end
    end

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_op == DOP_LOAD) |=> (dout_q == $past(wdata)));

    p_dir_load_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.dir_load |=> (dir_q == $past(wdata)));

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_op == DOP_SET) |=>
            (((dout_q & $past(wdata)) == $past(wdata)) &&
             ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));

    p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_op == DOP_CLR) |=>
            (((dout_q & $past(wdata)) == '0) &&
             ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));

    p_tgl_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_op == DOP_TGL) |=> ((dout_q ^ $past(dout_q)) == $past(wdata)));

    p_dir_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !cmd.dir_load |=> (dir_q == $past(dir_q)));

    p_dout_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.data_op == DOP_HOLD) |=> (dout_q == $past(dout_q)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    localparam int MIN_ADDR_W = $clog2(OFS_TGL + 1);

    if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
        initial $display("gpio_port_regs: ADDR_W too small for the register map");
    end

    wr_cmd_t             cmd;
    logic [NUM_PINS-1:0] dout_q;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] din_sync;

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_bus_decode #(
        .ADDR_W (ADDR_W),
        .WIDTH  (NUM_PINS)
    ) u_decode (
        .addr     (bus_addr),
        .we       (bus_we),
        .dout_q   (dout_q),
        .dir_q    (dir_q),
        .din_sync (din_sync),
        .cmd      (cmd),
        .rdata    (bus_rdata)
    );

    gpio_out_latch #(
        .WIDTH (NUM_PINS)
    ) u_latch (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .wdata  (bus_wdata),
        .dout_q (dout_q),
        .dir_q  (dir_q)
    );

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;

    p_oe_read_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_DIR) |-> (bus_rdata == pad_oe));

    p_out_read_r2: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == OFS_DOUT) |-> (bus_rdata == pad_out));

    p_alias_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) > OFS_DIN) |-> (bus_rdata == '0));

    p_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ((int'(bus_addr) == OFS_DIN) || (int'(bus_addr) > OFS_TGL))) |=>
            ((pad_out == $past(pad_out)) && (pad_oe == $past(pad_oe))));

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

    localparam int NP = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    always #2 clk = ~clk;

    gpio_port_regs #(.NUM_PINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Behavioural reference state.
    logic [NP-1:0] m_dout = '0;
    logic [NP-1:0] m_dir  = '0;
    logic [NP-1:0] pad_hist [$];
    int total = 0;
    int fails = 0;
    bit done  = 0;

    task automatic check(input logic [NP-1:0] act, input logic [NP-1:0] exp, input string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] m_din();
        return pad_hist[0];
    endfunction

    function automatic logic [NP-1:0] exp_read(input int a);
        case (a)
            0: return m_dout;
            1: return m_dir;
            2: return m_din();
            default: return '0;
        endcase
    endfunction

    task automatic step(input int a, input logic w, input logic [NP-1:0] d,
                        input logic [NP-1:0] p, input string tag);
        @(negedge clk);
        check(pad_out, m_dout, {tag, " pad_out"});
        check(pad_oe,  m_dir,  {tag, " pad_oe"});
        bus_addr  = a[AW-1:0];
        bus_we    = w;
        bus_wdata = d;
        pad_in    = p;
        #1;
        check(bus_rdata, exp_read(a), {tag, " rdata"});
        @(posedge clk);
        if (w) begin
            case (a)
                0: m_dout = d;
                1: m_dir  = d;
                3: m_dout = m_dout | d;
                4: m_dout = m_dout & ~d;
                5: m_dout = m_dout ^ d;
                default: ;
            endcase
        end
        // pad_hist[0] is what the synchronizer presents; [1] is the first stage.
        void'(pad_hist.pop_front());
        pad_hist.push_back(p);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        pad_hist.push_back('0);
        pad_hist.push_back('0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        check(pad_oe, '0, "R1 pad_oe in reset");
        check(pad_out, '0, "R1 pad_out in reset");
        rst = 1'b0;
        step(0, 0, '0, '0, "R1 data read after reset");
        step(1, 0, '0, '0, "R1 dir read after reset");
        // R12: preset the level while pins are inputs
        step(3, 1, 32'h0000_00F0, '0, "R12 preset via force-high");
        step(0, 0, '0, '0, "R12 preset held, pins still inputs");
        step(1, 1, 32'h0000_00FF, '0, "R4 direction write");
        step(1, 0, '0, '0, "R12 preset level driven with enable");
        step(4, 1, 32'h0000_0030, '0, "R6 force-low subset");
        step(5, 1, 32'hFF00_00C3, '0, "R7 invert subset");
        step(0, 0, '0, '0, "R7 readback");
        step(3, 1, '0, '0, "R5 empty mask leaves latch");
        step(4, 1, '0, '0, "R6 empty mask leaves latch");
        step(5, 1, '0, '0, "R7 empty mask leaves latch");
        step(0, 1, 32'hA5A5_5A5A, '0, "R3 full replace");
        step(1, 0, '0, '0, "R8 data write kept direction");
        step(1, 1, 32'h0F0F_F0F0, '0, "R4 direction replace");
        step(0, 0, '0, '0, "R8 direction write kept data");
        step(3, 1, 32'hFFFF_FFFF, '0, "R5 set all");
        step(4, 1, 32'h8000_0001, '0, "R6 clear edge bits");
        step(5, 1, 32'hFFFF_FFFF, '0, "R7 invert all");
        step(2, 1, 32'hFFFF_FFFF, '0, "R11 write to input view");
        step(6, 1, 32'h1234_5678, '0, "R11 write to unused offset 6");
        step(7, 1, 32'h8765_4321, '0, "R11 write to unused offset 7");
        step(0, 0, '0, '0, "R11 data unchanged");
        step(3, 0, '0, '0, "R10 force-high reads zero");
        step(4, 0, '0, '0, "R10 force-low reads zero");
        step(5, 0, '0, '0, "R10 invert reads zero");
        step(6, 0, '0, '0, "R10 unused reads zero");
        // R9: two-edge input latency
        step(2, 0, '0, 32'h1234_5678, "R9 pad change");
        step(2, 0, '0, 32'hDEAD_BEEF, "R9 one edge later");
        step(2, 0, '0, 32'h0000_0000, "R9 two edges later");
        step(2, 0, '0, 32'hFFFF_FFFF, "R9 next pattern");
        step(2, 0, '0, 32'h0000_0001, "R9 latency");
        step(2, 0, '0, 32'h0000_0001, "R9 latency");
        step(2, 0, '0, 32'h0000_0001, "R9 settled");
        // R2 and mixed traffic against the model
        for (int i = 0; i < 300; i++) begin
            int a;
            a = $urandom_range(0, 7);
            step(a, ($urandom_range(0, 3) != 0), $urandom, $urandom, "R2 mixed traffic");
        end
        @(negedge clk);
        check(pad_out, m_dout, "R2 final pad_out");
        check(pad_oe,  m_dir,  "R2 final pad_oe");
        done = 1;
        summary();
        $finish;
    end

endmodule